// File: doc/BRIEF.md
# Legacy Level Interrupt Router

This block carries level-sensitive legacy interrupts from the functions of several device slots to the numbered inputs of an interrupt controller. Each function drives an active-low request pin. The first stage assigns every function to one of a slot's four interrupt lanes (A to D), or drops the function. Several functions that share a lane are merged into that lane.

The second stage rotates each slot's four lanes onto four shared routing lines. The rotation advances by one position per slot, so the A lanes of consecutive slots land on different routing lines. The third stage steers each routing line onto a selectable controller input number, or disables it.

Every stage merges shared sources with an OR of the asserted requests. The controller input vector is registered. Configuration uses a one-cycle byte write port. The first `NSLOT*NFUNC` addresses hold the function lane selects. The next four addresses hold the routing-line targets.

Top module: `legacy_irq_router`

## Requirements
- R1: While reset is high, `irq_out` is all zeros. After reset, every function is assigned to lane A (select 0) and every routing line is disabled, so no request reaches `irq_out` until a route is written.
- R2: A function request is asserted when its pin `fn_req_n[s*NFUNC+f]` is low. `irq_out` is registered, and after each rising edge it reflects the request pins sampled at that edge.
- R3: A write to address `s*NFUNC+f` stores `wdata[2:0]` as the lane select of function f in slot s. Values 0, 1, 2 and 3 select lanes A, B, C and D. Any value of 4 or more removes the function from all lanes.
- R4: A lane is asserted while any function assigned to it is asserted. Releasing one of two sharing functions leaves the lane asserted.
- R5: Lane i of slot s (A=0 to D=3) drives routing line (i+s) mod 4.
- R6: A write to address `NSLOT*NFUNC+p` sets the target of routing line p. Bits [4:0] give the controller input number, and bit 7 set disables the route. A number of `NIRQ` or more drives no output.
- R7: A controller input is asserted while any routing line targeted at it is asserted, so several lines can share one input.
- R8: A configuration write presented before rising edge k takes effect at `irq_out` after edge k+1. The output after edge k still reflects the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Register address; AW = clog2(NSLOT*NFUNC+4) |
| cfg_wdata | input | 8 | Register write data |
| fn_req_n | input | NSLOT*NFUNC | Active-low function requests; bit s*NFUNC+f belongs to function f of slot s |
| irq_out | output | NIRQ | Active-high controller inputs, registered |

## Verification
A corrupted lane select, a wrong rotation offset or a stale route target shows as an interrupt on the wrong controller input. It can also show as a missing one. The symptom appears one edge after the first request that passes through the faulty path. The scoreboard therefore drives requests through every slot, through every lane that the bench reconfigures, and through shared, disabled and out-of-range routes, and compares the whole output vector each cycle. A separate check of the write-to-output timing catches an extra or a missing register in the configuration path.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int LANES   = 4;
  localparam int SELW    = 3;
  localparam int ROUTEW  = 8;
  localparam logic [SELW-1:0]   SEL_RESET   = 3'd0;
  localparam logic [ROUTEW-1:0] ROUTE_RESET = 8'h80;

  typedef struct packed {
    logic       off;
    logic [1:0] spare;
    logic [4:0] num;
  } route_t;
endpackage

// File: rtl/lir_cfg_regs.sv
module lir_cfg_regs
  import lir_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int NFUNC = 8,
  localparam int NMAP = NSLOT * NFUNC,
  localparam int AW   = $clog2(NMAP + LANES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [7:0]               wdata,
  output logic [NMAP*SELW-1:0]     sel_flat,
  output logic [LANES*ROUTEW-1:0]  route_flat
);
  for (genvar i = 0; i < NMAP; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)
        sel_flat[i*SELW +: SELW] <= SEL_RESET;
      else if (we && addr == AW'(i))
        sel_flat[i*SELW +: SELW] <= wdata[SELW-1:0];
    end

    // R3: a lane-select write lands in its register on the next edge
    a_r3_sel_write: assert property (@(posedge clk) disable iff (rst)
      (we && addr == AW'(i)) |=> sel_flat[i*SELW +: SELW] == $past(wdata[SELW-1:0]));
  end

  for (genvar p = 0; p < LANES; p++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst)
        route_flat[p*ROUTEW +: ROUTEW] <= ROUTE_RESET;
      else if (we && addr == AW'(NMAP + p))
        route_flat[p*ROUTEW +: ROUTEW] <= wdata;
    end

    // R6: a route write lands in its register on the next edge
    a_r6_route_write: assert property (@(posedge clk) disable iff (rst)
      (we && addr == AW'(NMAP + p)) |=> route_flat[p*ROUTEW +: ROUTEW] == $past(wdata));

    // R1: reset leaves every route disabled
    a_r1_route_reset: assert property (@(posedge clk)
      rst |=> route_flat[p*ROUTEW + ROUTEW - 1]);
  end
endmodule

// File: rtl/lir_func_lanes.sv
module lir_func_lanes
  import lir_pkg::*;
#(
  parameter int NFUNC = 8
) (
  input  logic [NFUNC-1:0]      req,
  input  logic [NFUNC*SELW-1:0] sel,
  output logic [LANES-1:0]      lanes
);
  always_comb begin
    lanes = '0;
    for (int f = 0; f < NFUNC; f++) begin
      if (req[f] && sel[f*SELW + SELW - 1] == 1'b0)
        lanes[sel[f*SELW +: 2]] = 1'b1;
    end
  end
endmodule

// File: rtl/lir_line_route.sv
module lir_line_route
  import lir_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int NIRQ  = 24
) (
  input  logic [NSLOT*LANES-1:0]  lanes,
  input  logic [LANES*ROUTEW-1:0] route_flat,
  output logic [NIRQ-1:0]         irq_next
);
  logic [LANES-1:0][NSLOT-1:0] hit;
  logic [LANES-1:0]            line;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign hit[(i + s) % LANES][s] = lanes[s*LANES + i];
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : g_line
    assign line[p] = |hit[p];
  end

  always_comb begin
    route_t r;
    irq_next = '0;
    for (int p = 0; p < LANES; p++) begin
      r = route_t'(route_flat[p*ROUTEW +: ROUTEW]);
      for (int q = 0; q < NIRQ; q++) begin
        if (line[p] && !r.off && r.num == 5'(q))
          irq_next[q] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
  import lir_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int NFUNC = 8,
  parameter int NIRQ  = 24,
  localparam int NMAP = NSLOT * NFUNC,
  localparam int AW   = $clog2(NMAP + LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic [NMAP-1:0]  fn_req_n,
  output logic [NIRQ-1:0]  irq_out
);
  logic [NMAP*SELW-1:0]     sel_flat;
  logic [LANES*ROUTEW-1:0]  route_flat;
  logic [NMAP-1:0]          req;
  logic [NSLOT*LANES-1:0]   lanes;
  logic [NIRQ-1:0]          irq_next;

  assign req = ~fn_req_n;

  lir_cfg_regs #(.NSLOT(NSLOT), .NFUNC(NFUNC)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel_flat(sel_flat), .route_flat(route_flat)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    lir_func_lanes #(.NFUNC(NFUNC)) u_lanes (
      .req  (req[s*NFUNC +: NFUNC]),
      .sel  (sel_flat[s*NFUNC*SELW +: NFUNC*SELW]),
      .lanes(lanes[s*LANES +: LANES])
    );
  end

  lir_line_route #(.NSLOT(NSLOT), .NIRQ(NIRQ)) u_route (
    .lanes(lanes), .route_flat(route_flat), .irq_next(irq_next)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= irq_next;
  end

  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int p = 0; p < LANES; p++)
      all_off &= route_flat[p*ROUTEW + ROUTEW - 1];
  end

  // R1: outputs cleared by reset
  a_r1_out_cleared: assert property (@(posedge clk) rst |=> irq_out == '0);

  // R2: no asserted pin at the sampling edge means a quiet output after it
  a_r2_quiet_inputs: assert property (@(posedge clk) disable iff (rst)
    (&$past(fn_req_n)) |-> irq_out == '0);

  // R6: with every route disabled nothing reaches the controller
  a_r6_all_routes_off: assert property (@(posedge clk) disable iff (rst)
    $past(all_off) |-> irq_out == '0);
endmodule

// File: tb/sim_legacy_irq_router.sv
`timescale 1ns/100ps
module sim_legacy_irq_router;
  localparam int NSLOT = 4, NFUNC = 8, NIRQ = 24, NMAP = NSLOT*NFUNC;
  localparam int AW = $clog2(NMAP + 4);

  logic clk = 1'b0, rst = 1'b1, cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [NMAP-1:0] fn_req_n = '1;
  logic [NIRQ-1:0] irq_out;

  int checks = 0, fails = 0;
  logic [2:0] m_sel [NMAP];
  logic [7:0] m_route [4];
  logic [NIRQ-1:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  legacy_irq_router #(.NSLOT(NSLOT), .NFUNC(NFUNC), .NIRQ(NIRQ)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fn_req_n(fn_req_n), .irq_out(irq_out)
  );

  function automatic logic [NIRQ-1:0] model(input logic [NMAP-1:0] rn);
    logic [3:0] line = '0;
    logic [NIRQ-1:0] o = '0;
    for (int s = 0; s < NSLOT; s++)
      for (int f = 0; f < NFUNC; f++)
        if (!rn[s*NFUNC+f] && m_sel[s*NFUNC+f] < 4)
          line[(int'(m_sel[s*NFUNC+f]) + s) % 4] = 1'b1;
    for (int p = 0; p < 4; p++)
      if (line[p] && !m_route[p][7] && int'(m_route[p][4:0]) < NIRQ)
        o[m_route[p][4:0]] = 1'b1;
    return o;
  endfunction

  task automatic check(input logic [NIRQ-1:0] act, input logic [NIRQ-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_out=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NMAP) m_sel[a] = d[2:0];
    else m_route[a-NMAP] = d;
  endtask

  task automatic apply(input logic [NMAP-1:0] rn, input string tag);
    @(negedge clk);
    fn_req_n = rn;
    exp_q.push_back(model(rn));
    tag_q.push_back(tag);
  endtask

  function automatic logic [NMAP-1:0] pins(input int a, input int b = -1);
    logic [NMAP-1:0] r = '1;
    r[a] = 1'b0;
    if (b >= 0) r[b] = 1'b0;
    return r;
  endfunction

  // monitor: pops one expected item per edge after the driver posts it
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() != 0) check(irq_out, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NMAP; i++) m_sel[i] = 3'd0;
    for (int p = 0; p < 4; p++) m_route[p] = 8'h80;
    repeat (3) @(posedge clk);
    #1 check(irq_out, '0, "R1 reset output");
    @(negedge clk); rst = 1'b0;

    apply(pins(0), "R1 routes disabled after reset");
    for (int p = 0; p < 4; p++) cfg_write(NMAP + p, 8'(16 + p));
    for (int s = 0; s < NSLOT; s++) apply(pins(s*NFUNC), "R5 slot lane A rotation");
    apply(pins(2*NFUNC + 7), "R1 default select lane A");
    apply(pins(0) & pins(3*NFUNC + 4), "R2 two slots active");

    cfg_write(1*NFUNC + 3, 8'd2);
    apply(pins(1*NFUNC + 3), "R3 select lane C");
    cfg_write(2*NFUNC + 5, 8'd5);
    apply(pins(2*NFUNC + 5), "R3 select 5 removes function");
    cfg_write(2*NFUNC + 6, 8'd4);
    apply(pins(2*NFUNC + 6), "R3 select 4 removes function");

    apply(pins(0, 1), "R4 two functions share lane");
    apply(pins(1), "R4 one sharer released");
    apply('1, "R2 all released");

    cfg_write(NMAP + 1, 8'd16);
    apply(pins(1*NFUNC), "R7 second line to shared input");
    apply(pins(0, 1*NFUNC), "R7 two lines one input");

    cfg_write(NMAP + 2, 8'd30);
    apply(pins(2*NFUNC), "R6 out of range number");
    cfg_write(NMAP + 3, 8'h93);
    apply(pins(3*NFUNC), "R6 disable bit");
    cfg_write(NMAP + 2, 8'd5);
    cfg_write(3*NFUNC + 2, 8'd3);
    apply(pins(3*NFUNC + 2), "R5 slot 3 lane D");

    // R8: write-to-output latency
    apply(pins(0), "R8 setup");
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(NMAP); cfg_wdata = 8'd20;
    @(posedge clk); #1;
    check(irq_out, 24'h1 << 16, "R8 old route after first edge");
    @(negedge clk); cfg_we = 1'b0; m_route[0] = 8'd20;
    @(posedge clk); #1;
    check(irq_out, 24'h1 << 20, "R8 new route after second edge");

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule